// File: doc/BRIEF.md
# Majority-Vote UART Receive Engine

This block receives 10-bit asynchronous frames: one low start bit, eight data bits with the least significant first, and one stop bit. The serial input passes through a two-flop synchronizer. It is then sampled on an oversampling enable (`tick16`) that runs at sixteen times the bit rate. A falling edge seen between two consecutive ticks starts a frame. That edge clears a 4-bit phase counter and loads all ones into a 9-bit assembly register.

In each bit time the line is sampled at phase counts 7, 8 and 9, and the bit takes the value held by at least two of the three samples. If the voted start bit is high, the frame is dropped and edge search resumes. Each accepted bit shifts in at the right of the assembly register. When the start bit's zero reaches bit 8 (the leftmost position), the next voted bit is the stop bit and closes the frame. That frame is delivered only if the ready flag is clear and the stop-bit filter either is off or sees a high stop bit. A delivered frame loads the byte register and the stop register and sets the ready flag, which stays set until the host pulses `ready_clr`.

Top module: `uart_vote_rx`

## Requirements
- R1: While `rx_en` is 1 and the receiver is idle, a line value of 1 on one tick followed by 0 on the next tick starts a frame. The synchronizer delays the line by two clocks before this detection.
- R2: Each bit is decided at the tick where the phase counter reads 9, counting ticks from the start edge (count 0). The accepted value is the majority of the line samples at counts 7, 8 and 9, so a disturbance that reaches only one of these samples does not change the bit.
- R3: A voted start bit of 1 abandons the frame without touching any output. The receiver then waits for the next falling edge, and a valid frame that follows is received normally.
- R4: Data bits arrive least significant first: `rx_byte[i]` equals the i-th data bit after the start bit, for i = 0 to 7.
- R5: The frame closes on the 10th voted bit. The stop bit is that 10th bit, and the close is reached when the start bit's zero stands in bit 8 of the 9-bit register.
- R6: A closing frame is delivered only if `rx_ready` is 0 and either `filt_en` is 0 or the stop bit is 1.
- R7: A frame that is not delivered leaves `rx_byte`, `rx_stop` and `rx_ready` unchanged.
- R8: On delivery, `rx_byte` takes the data bits, `rx_stop` takes the stop bit and `rx_ready` becomes 1. After the close, edge search resumes whether or not the frame was delivered.
- R9: A one-cycle pulse on `ready_clr` clears `rx_ready`.
- R10: While `rx_en` is 0 the receiver stays idle, and a frame sent during that time is ignored.
- R11: After reset, `rx_byte` is 0, `rx_stop` is 0 and `rx_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, one pulse per sixteenth of a bit |
| rx_en | input | 1 | Receive enable; 0 holds the receiver idle |
| rx_in | input | 1 | Asynchronous serial input, idles high |
| filt_en | input | 1 | Stop-bit filter: when 1, a frame with a low stop bit is dropped |
| ready_clr | input | 1 | One-cycle pulse that clears the ready flag |
| rx_byte | output | 8 | Last delivered data byte |
| rx_stop | output | 1 | Stop bit of the last delivered frame |
| rx_ready | output | 1 | Set when a frame is delivered |

## Verification
All 256 byte values are sent with a high stop bit. Half of these frames carry a one-tick pulse of the wrong polarity in the middle of every bit. This pulse separates true majority voting from single-sample decoding, and the clean frames separate correct bit order from a reversed order. Frames with a low stop bit are sent with the filter on and with the filter off, which shows whether the stop-bit condition is applied. A frame sent while `rx_ready` is still set tests the ready-flag condition, and a short low pulse on an idle line tests the false-start recovery. A frame sent with `rx_en` low tests that the enable really holds the receiver idle.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
  localparam int RXV_DATA_W = 8;

  typedef enum logic {ST_IDLE, ST_RECV} rxv_state_t;

  // two-of-three majority
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // assembly register holds the first data bit at the top: reverse into a byte
  function automatic logic [RXV_DATA_W-1:0] unpack_byte(input logic [RXV_DATA_W-1:0] sh);
    logic [RXV_DATA_W-1:0] r;
    for (int i = 0; i < RXV_DATA_W; i++) r[i] = sh[RXV_DATA_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/rxv_sync.sv
module rxv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= d_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rxv_vote.sv
module rxv_vote #(
  parameter int OSR = 16,
  localparam int CW = $clog2(OSR),
  localparam int MID = OSR / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          active,
  input  logic [CW-1:0] phase,
  input  logic          line,
  output logic          bit_valid,
  output logic          bit_val
);
  import rxv_pkg::*;

  logic samp_a, samp_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_a <= 1'b1;
      samp_b <= 1'b1;
    end else if (tick && active) begin
      if (phase == CW'(MID-1)) samp_a <= line;
      if (phase == CW'(MID))   samp_b <= line;
    end
  end

  assign bit_valid = tick && active && (phase == CW'(MID+1));
  assign bit_val   = maj3(samp_a, samp_b, line);

  // R2: two agreeing early samples decide the bit
  assert_vote_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && (samp_a == samp_b)) |-> (bit_val == samp_a));
endmodule

// File: rtl/rxv_frame.sv
module rxv_frame #(
  parameter int OSR = 16,
  localparam int CW = $clog2(OSR),
  localparam int DW = rxv_pkg::RXV_DATA_W,
  localparam int SW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_en,
  input  logic          line,
  input  logic          bit_valid,
  input  logic          bit_val,
  input  logic          filt_en,
  input  logic          ready_clr,
  output logic          active,
  output logic [CW-1:0] phase,
  output logic [DW-1:0] rx_byte,
  output logic          rx_stop,
  output logic          rx_ready
);
  import rxv_pkg::*;

  rxv_state_t    state;
  logic [SW-1:0] shreg;
  logic          prev_line;

  // named internal events
  logic edge_hit, first_bit, false_start, final_shift, deliver;

  assign active      = (state == ST_RECV);
  assign edge_hit    = tick && rx_en && !active && prev_line && !line;
  assign first_bit   = (shreg == {SW{1'b1}});
  assign false_start = bit_valid && active && first_bit && bit_val;
  assign final_shift = bit_valid && active && !shreg[SW-1];
  assign deliver     = final_shift && !rx_ready && (!filt_en || bit_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_line <= 1'b1;
    else if (tick) prev_line <= line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= '0;
      shreg <= {SW{1'b1}};
    end else if (!rx_en) begin
      state <= ST_IDLE;
    end else if (edge_hit) begin
      state <= ST_RECV;
      phase <= '0;
      shreg <= {SW{1'b1}};
    end else if (active && tick) begin
      phase <= phase + 1'b1;
      if (false_start || final_shift) state <= ST_IDLE;
      else if (bit_valid) shreg <= {shreg[SW-2:0], bit_val};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte  <= '0;
      rx_stop  <= 1'b0;
      rx_ready <= 1'b0;
    end else if (deliver) begin
      rx_byte  <= unpack_byte(shreg[DW-1:0]);
      rx_stop  <= bit_val;
      rx_ready <= 1'b1;
    end else if (ready_clr) begin
      rx_ready <= 1'b0;
    end
  end

  assert_start_preload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> (active && phase == '0 && shreg == {SW{1'b1}}));
  assert_false_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> !active);
  assert_close_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    final_shift |=> !active);
  assert_ready_from_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(final_shift));
  assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver |=> ($stable(rx_byte) && $stable(rx_stop)));
  assert_clear_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_clr && !deliver) |=> !rx_ready);
  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !active);
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int OSR = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(OSR),
  localparam int DW = rxv_pkg::RXV_DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          rx_in,
  input  logic          filt_en,
  input  logic          ready_clr,
  output logic [DW-1:0] rx_byte,
  output logic          rx_stop,
  output logic          rx_ready
);
  logic          line_s;
  logic          active;
  logic [CW-1:0] phase;
  logic          bit_valid, bit_val;

  rxv_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(line_s)
  );

  rxv_vote #(.OSR(OSR)) i_vote (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .active(active), .phase(phase),
    .line(line_s), .bit_valid(bit_valid), .bit_val(bit_val)
  );

  rxv_frame #(.OSR(OSR)) i_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_en(rx_en), .line(line_s),
    .bit_valid(bit_valid), .bit_val(bit_val), .filt_en(filt_en),
    .ready_clr(ready_clr), .active(active), .phase(phase),
    .rx_byte(rx_byte), .rx_stop(rx_stop), .rx_ready(rx_ready)
  );
endmodule

// File: tb/test_uart_vote_rx.sv
`timescale 1ns/1ps
module test_uart_vote_rx;
  localparam int BIT_CLK = 32;   // tick every 2 clocks, 16 ticks per bit

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
  logic rx_en = 1'b1, rx_in = 1'b1, filt_en = 1'b0, ready_clr = 1'b0;
  logic [7:0] rx_byte;
  logic rx_stop, rx_ready;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(negedge clk) tick16 <= rst_n ? ~tick16 : 1'b0;

  uart_vote_rx i_uart_vote_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en), .rx_in(rx_in),
    .filt_en(filt_en), .ready_clr(ready_clr),
    .rx_byte(rx_byte), .rx_stop(rx_stop), .rx_ready(rx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one bit; optional one-tick pulse of inverted value at its centre
  task automatic drive_bit(input logic v, input logic glitch);
    for (int c = 0; c < BIT_CLK; c++) begin
      @(negedge clk);
      rx_in = (glitch && (c == 16 || c == 17)) ? ~v : v;
    end
  endtask

  task automatic send(input logic [7:0] b, input logic stop, input logic glitch);
    drive_bit(1'b0, glitch);
    for (int i = 0; i < 8; i++) drive_bit(b[i], glitch);
    drive_bit(stop, glitch);
    @(negedge clk); rx_in = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic clear_ready();
    @(negedge clk); ready_clr = 1'b1;
    @(negedge clk); ready_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R11 byte after reset", rx_byte, 0);
    chk("R11 stop after reset", rx_stop, 0);
    chk("R11 ready after reset", rx_ready, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R4 R8 R2: full byte sweep, odd bytes with mid-bit noise
    for (int b = 0; b < 256; b++) begin
      send(8'(b), 1'b1, b[0]);
      chk(b[0] ? "R2 noisy byte" : "R4 byte order", rx_byte, b);
      chk("R8 stop stored", rx_stop, 1);
      chk("R8 ready set", rx_ready, 1);
      clear_ready();
      chk("R9 ready cleared", rx_ready, 0);
    end

    // R6/R7: low stop bit with filter on -> dropped
    filt_en = 1'b1;
    send(8'h3C, 1'b0, 1'b0);
    chk("R6 filtered ready", rx_ready, 0);
    chk("R7 filtered byte kept", rx_byte, 8'hFF);
    // R5/R8: next frame after the drop is received (resumed search)
    send(8'hC3, 1'b1, 1'b0);
    chk("R5 frame after drop", rx_byte, 8'hC3);
    clear_ready();

    // R6: low stop bit with filter off -> delivered, rx_stop=0
    filt_en = 1'b0;
    send(8'h96, 1'b0, 1'b0);
    chk("R6 unfiltered byte", rx_byte, 8'h96);
    chk("R6 unfiltered stop", rx_stop, 0);
    chk("R6 unfiltered ready", rx_ready, 1);

    // R6/R7: ready still set -> new frame lost
    send(8'h5A, 1'b1, 1'b0);
    chk("R7 busy byte kept", rx_byte, 8'h96);
    chk("R7 busy stop kept", rx_stop, 0);
    chk("R6 busy ready", rx_ready, 1);
    clear_ready();

    // R3: short low pulse then a valid frame
    @(negedge clk); rx_in = 1'b0;
    repeat (8) @(negedge clk);
    rx_in = 1'b1;
    repeat (BIT_CLK * 2) @(negedge clk);
    chk("R3 false start ready", rx_ready, 0);
    chk("R3 false start byte", rx_byte, 8'h96);
    send(8'hA5, 1'b1, 1'b0);
    chk("R3 frame after false start", rx_byte, 8'hA5);
    chk("R1 frame after false start ready", rx_ready, 1);
    clear_ready();

    // R10: frame while disabled is ignored
    rx_en = 1'b0;
    send(8'h0F, 1'b1, 1'b0);
    chk("R10 disabled ready", rx_ready, 0);
    chk("R10 disabled byte", rx_byte, 8'hA5);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    send(8'hF0, 1'b1, 1'b1);
    chk("R1 re-enabled byte", rx_byte, 8'hF0);
    chk("R1 re-enabled ready", rx_ready, 1);

    summary();
  end
endmodule